// File: doc/BRIEF.md
# Wavefront Lane Permute Network

This block moves 32-bit operands between the 64 lanes of a wavefront in a single pass. Each row holds 16 lanes and each bank holds 4 lanes, so the wavefront has four rows and each row has four banks. A 9-bit control value chooses the routing pattern. The available patterns are:

- a free permute inside every group of four lanes
- shifts or rotates confined to a row
- one-lane shifts or rotates across the whole wavefront
- mirrors over a full row or a half row
- two broadcast forms that copy a single lane into later rows

The outputs are the routed operand vector and a write-enable bit for each lane. A downstream ALU and register file consume both.

A lane is blocked from writing if its row or bank is masked off. A lane whose source falls outside the wavefront or outside its row is handled by a boundary flag: with the flag set the lane writes zero, and with the flag clear the lane does not write. Control values that match no pattern pass the operand straight through, and every lane writes.

The routing is combinational. Both outputs are registered once, and the registers use a synchronous, active-high reset.

Top module: `lperm_net`

## Requirements
- R1: A control below 0x100 is a quad permute. Lane i takes lane (i & ~3) + ((ctrl >> 2*(i & 3)) & 3). Every source is valid.
- R2: Controls 0x101..0x10F shift left within a row by N = ctrl[3:0], so lane i takes lane i+N. Controls 0x111..0x11F shift right within a row, so lane i takes lane i-N. A source that would leave the row is invalid.
- R3: Controls 0x121..0x12F rotate right within a row. Lane i takes row base + ((i mod 16) - N) mod 16. Every source is valid.
- R4: The four wave-wide moves are:
  - 0x130: lane i takes lane i+1, and lane 63 is invalid.
  - 0x138: lane i takes lane i-1, and lane 0 is invalid.
  - 0x134: lane i takes lane (i+1) mod 64.
  - 0x13C: lane i takes lane (i-1) mod 64.
- R5: Control 0x140 mirrors each 16-lane row, so lane i takes (i & ~15) | ((i & 15) ^ 15). Control 0x141 mirrors each 8-lane half row, so lane i takes (i & ~7) | ((i & 7) ^ 7).
- R6: Control 0x142 gives every lane of row r ≥ 1 the value of lane 16r-1, and row 0 keeps its own values. Control 0x143 gives every lane of rows 2 and 3 the value of lane 31, and rows 0 and 1 keep their own values.
- R7: A lane with an invalid source outputs zero data. Its write-enable follows `bound_zero_i`: 1 writes zero, and 0 suppresses the write.
- R8: For a defined control, lane i writes only if `row_en_i[i>>4]` and `bank_en_i[(i>>2)&3]` are both 1.
- R9: An undefined control passes lane i's own operand through, with every write-enable set regardless of the masks. The undefined values are 0x100, 0x110, 0x120, 0x131..0x133, 0x135..0x137, 0x139..0x13B, 0x13D..0x13F and 0x144..0x1FF.
- R10: Outputs appear on the clock edge after their inputs. A reset edge clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 9 | Routing pattern select |
| bound_zero_i | input | 1 | 1: invalid-source lanes write zero; 0: they do not write |
| row_en_i | input | 4 | Bit k enables row k (lanes 16k..16k+15) |
| bank_en_i | input | 4 | Bit b enables bank b of every row |
| src_i | input | 64*DATA_W | Operand vector, lane i at bits [DATA_W*i +: DATA_W] |
| res_o | output | 64*DATA_W | Routed operand vector, registered |
| lane_we_o | output | 64 | Per-lane write-enable, registered |

## Verification
The assertions are checked on every cycle and cover the behaviours that hold whatever the data:
- reset clears both outputs;
- undefined controls pass the operand through with every lane enabled;
- no enable bit is set outside the row and bank masks;
- the whole mask is enabled whenever every source is valid or the boundary flag is set.

Checking which lane each lane actually reads from needs the bench's sweep. It applies all 512 control values with distinct per-lane data and compares the results against an independent index model. Its scenarios also cover the edge lanes where shifts run out of range, the broadcast rows, and all row and bank mask pairs combined with both flag settings.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

  localparam int unsigned LANES     = 64;
  localparam int unsigned ROW_LANES = 16;
  localparam int unsigned HALF_ROW  = ROW_LANES / 2;
  localparam int unsigned QUAD      = 4;
  localparam int unsigned ROWS      = LANES / ROW_LANES;
  localparam int unsigned BANKS     = ROW_LANES / QUAD;
  localparam int unsigned LIDX_W    = $clog2(LANES);
  localparam int unsigned CTRL_W    = 9;

  typedef enum logic [3:0] {
    OP_QUAD, OP_RSHL, OP_RSHR, OP_RROR,
    OP_WSHL, OP_WROL, OP_WSHR, OP_WROR,
    OP_MIR,  OP_HMIR, OP_BC15, OP_BC31,
    OP_NONE
  } op_t;

  typedef struct packed {
    logic [LIDX_W-1:0] idx;
    logic              ok;
  } route_t;

  // Source lane for one destination lane under a decoded pattern.
  function automatic route_t lane_route(op_t op, logic [3:0] amt,
                                        logic [7:0] qsel, int unsigned lane);
    route_t r;
    int loc, base, n, s, q;
    loc  = int'(lane % ROW_LANES);
    base = int'(lane) - loc;
    n    = int'(amt);
    s    = int'(lane);
    r.ok = 1'b1;
    case (op)
      OP_QUAD: begin
        q = int'((qsel >> (2 * (lane % QUAD))) & 8'd3);
        s = int'(lane) - int'(lane % QUAD) + q;
      end
      OP_RSHL: if (loc + n > int'(ROW_LANES) - 1) r.ok = 1'b0;
               else s = base + loc + n;
      OP_RSHR: if (loc < n) r.ok = 1'b0;
               else s = base + loc - n;
      OP_RROR: s = base + ((loc - n + int'(ROW_LANES)) % int'(ROW_LANES));
      OP_WSHL: if (lane == LANES - 1) r.ok = 1'b0;
               else s = int'(lane) + 1;
      OP_WROL: s = int'((lane + 1) % LANES);
      OP_WSHR: if (lane == 0) r.ok = 1'b0;
               else s = int'(lane) - 1;
      OP_WROR: s = int'((lane + LANES - 1) % LANES);
      OP_MIR:  s = base + (loc ^ (int'(ROW_LANES) - 1));
      OP_HMIR: s = int'(lane) - int'(lane % HALF_ROW)
                   + (int'(lane % HALF_ROW) ^ (int'(HALF_ROW) - 1));
      OP_BC15: if (lane >= ROW_LANES) s = base - 1;
      OP_BC31: if (lane >= 2 * ROW_LANES) s = 2 * int'(ROW_LANES) - 1;
      default: s = int'(lane);
    endcase
    r.idx = r.ok ? LIDX_W'(s) : LIDX_W'(lane);
    return r;
  endfunction

endpackage

// File: rtl/lperm_decode.sv
module lperm_decode
  import lperm_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output op_t               op_o,
  output logic [3:0]        amt_o,
  output logic [7:0]        qsel_o,
  output logic              known_o
);
  always_comb begin
    op_o   = OP_NONE;
    amt_o  = ctrl_i[3:0];
    qsel_o = ctrl_i[7:0];
    if (!ctrl_i[8]) begin
      op_o = OP_QUAD;
    end else begin
      case (ctrl_i[7:4])
        4'h0: if (ctrl_i[3:0] != 4'h0) op_o = OP_RSHL;
        4'h1: if (ctrl_i[3:0] != 4'h0) op_o = OP_RSHR;
        4'h2: if (ctrl_i[3:0] != 4'h0) op_o = OP_RROR;
        4'h3: begin
          case (ctrl_i[3:0])
            4'h0:    op_o = OP_WSHL;
            4'h4:    op_o = OP_WROL;
            4'h8:    op_o = OP_WSHR;
            4'hC:    op_o = OP_WROR;
            default: op_o = OP_NONE;
          endcase
        end
        4'h4: begin
          case (ctrl_i[3:0])
            4'h0:    op_o = OP_MIR;
            4'h1:    op_o = OP_HMIR;
            4'h2:    op_o = OP_BC15;
            4'h3:    op_o = OP_BC31;
            default: op_o = OP_NONE;
          endcase
        end
        default: op_o = OP_NONE;
      endcase
    end
    known_o = (op_o != OP_NONE);
  end
endmodule

// File: rtl/lperm_lane.sv
module lperm_lane
  import lperm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE   = 0
) (
  input  op_t                    op_i,
  input  logic [3:0]             amt_i,
  input  logic [7:0]             qsel_i,
  input  logic [LANES*DATA_W-1:0] src_i,
  output logic [DATA_W-1:0]      data_o,
  output logic                   ok_o
);
  route_t            rt_w;
  logic [LIDX_W-1:0] src_idx_w;

  always_comb begin
    rt_w      = lane_route(op_i, amt_i, qsel_i, LANE);
    src_idx_w = rt_w.idx;
    ok_o      = rt_w.ok;
    data_o    = rt_w.ok ? src_i[src_idx_w*DATA_W +: DATA_W] : '0;
  end
endmodule

// File: rtl/lperm_gate.sv
module lperm_gate
  import lperm_pkg::*;
(
  input  logic [ROWS-1:0]  row_en_i,
  input  logic [BANKS-1:0] bank_en_i,
  input  logic [LANES-1:0] ok_i,
  input  logic             bound_zero_i,
  input  logic             known_i,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] we_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned ROW  = l / ROW_LANES;
    localparam int unsigned BANK = (l / QUAD) % BANKS;
    assign mask_o[l] = row_en_i[ROW] & bank_en_i[BANK];
    assign we_o[l]   = known_i ? (mask_o[l] & (ok_i[l] | bound_zero_i)) : 1'b1;
  end
endmodule

// File: rtl/lperm_net.sv
module lperm_net
  import lperm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [8:0]               ctrl_i,
  input  logic                     bound_zero_i,
  input  logic [3:0]               row_en_i,
  input  logic [3:0]               bank_en_i,
  input  logic [64*DATA_W-1:0]     src_i,
  output logic [64*DATA_W-1:0]     res_o,
  output logic [63:0]              lane_we_o
);
  localparam int unsigned VEC_W = LANES * DATA_W;

  op_t              op_w;
  logic [3:0]       amt_w;
  logic [7:0]       qsel_w;
  logic             known_w;
  logic [VEC_W-1:0] route_w;
  logic [LANES-1:0] ok_w;
  logic [LANES-1:0] mask_w;
  logic [LANES-1:0] we_w;
  logic             all_ok_w;
  logic [VEC_W-1:0] next_res_w;

  lperm_decode u_dec (
    .ctrl_i (ctrl_i),
    .op_o   (op_w),
    .amt_o  (amt_w),
    .qsel_o (qsel_w),
    .known_o(known_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lperm_lane #(.DATA_W(DATA_W), .LANE(l)) u_lane (
      .op_i  (op_w),
      .amt_i (amt_w),
      .qsel_i(qsel_w),
      .src_i (src_i),
      .data_o(route_w[l*DATA_W +: DATA_W]),
      .ok_o  (ok_w[l])
    );
  end

  lperm_gate u_gate (
    .row_en_i    (row_en_i),
    .bank_en_i   (bank_en_i),
    .ok_i        (ok_w),
    .bound_zero_i(bound_zero_i),
    .known_i     (known_w),
    .mask_o      (mask_w),
    .we_o        (we_w)
  );

  assign all_ok_w   = &ok_w;
  assign next_res_w = known_w ? route_w : src_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      lane_we_o <= '0;
    end else begin
      res_o     <= next_res_w;
      lane_we_o <= we_w;
    end
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0) && (lane_we_o == '0));

  // R9
  undef_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !known_w |=> (res_o == $past(src_i)) && (lane_we_o == '1));

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    known_w |=> (lane_we_o & ~$past(mask_w)) == '0);

  // R7
  bound_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (known_w && bound_zero_i) |=> lane_we_o == $past(mask_w));

  // R3
  full_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (known_w && (op_w == OP_RROR || op_w == OP_QUAD || op_w == OP_MIR)) |=>
      lane_we_o == $past(mask_w));

  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (known_w && !all_ok_w && !bound_zero_i) |=> lane_we_o != $past(mask_w) || $past(mask_w & ~ok_w) == '0);

endmodule

// File: tb/lperm_net_tb_top.sv
module lperm_net_tb_top;
  localparam int DW = 32;
  localparam int NL = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [8:0]        ctrl = '0;
  logic              bz = 1'b0;
  logic [3:0]        row_en = 4'hF;
  logic [3:0]        bank_en = 4'hF;
  logic [NL*DW-1:0]  src = '0;
  logic [NL*DW-1:0]  res;
  logic [NL-1:0]     we;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  lperm_net #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .bound_zero_i(bz),
    .row_en_i(row_en), .bank_en_i(bank_en), .src_i(src),
    .res_o(res), .lane_we_o(we)
  );

  function automatic logic [DW-1:0] lane_val(int i, int salt);
    return {8'(i + 1 + salt), 8'(255 - i), 16'(16'h5A00 + i * 3 + salt)};
  endfunction

  // Independent reference: returns 0 if undefined, 1 if defined.
  function automatic bit ref_map(int c, int lane, output int s, output bit ok);
    int row, loc;
    row = lane / 16; loc = lane % 16; s = lane; ok = 1;
    if (c < 256) begin
      s = (lane / 4) * 4 + ((c >> (2 * (lane % 4))) % 4); return 1;
    end
    if (c > 256 && c < 272) begin
      s = lane + (c - 256); ok = (s / 16 == row) && (s < 64); return 1;
    end
    if (c > 272 && c < 288) begin
      s = lane - (c - 272); ok = (s >= 0) && (s / 16 == row); return 1;
    end
    if (c > 288 && c < 304) begin
      s = row * 16 + (loc + 16 - (c - 288)) % 16; return 1;
    end
    case (c)
      304: begin s = lane + 1; ok = (lane != 63); return 1; end
      308: begin s = (lane + 1) % 64; return 1; end
      312: begin s = lane - 1; ok = (lane != 0); return 1; end
      316: begin s = (lane + 63) % 64; return 1; end
      320: begin s = row * 16 + 15 - loc; return 1; end
      321: begin s = (lane / 8) * 8 + 7 - lane % 8; return 1; end
      322: begin if (row > 0) s = row * 16 - 1; return 1; end
      323: begin if (row > 1) s = 31; return 1; end
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int c);
    if (c < 256) return "R1";
    if ((c > 256 && c < 272) || (c > 272 && c < 288)) return "R2";
    if (c > 288 && c < 304) return "R3";
    if (c == 304 || c == 308 || c == 312 || c == 316) return "R4";
    if (c == 320 || c == 321) return "R5";
    if (c == 322 || c == 323) return "R6";
    return "R9";
  endfunction

  task automatic load_src(int salt);
    for (int i = 0; i < NL; i++) src[i*DW +: DW] = lane_val(i, salt);
  endtask

  // Drive at negedge, sample at the next negedge (one register stage).
  task automatic run_case(int c, bit flag, logic [3:0] re, logic [3:0] be, string tag);
    logic [NL*DW-1:0] exp_res;
    logic [NL-1:0]    exp_we;
    int s; bit ok, def, bad_d, bad_w;
    ctrl = 9'(c); bz = flag; row_en = re; bank_en = be;
    for (int l = 0; l < NL; l++) begin
      def = ref_map(c, l, s, ok);
      if (!def) begin
        exp_res[l*DW +: DW] = src[l*DW +: DW]; exp_we[l] = 1'b1;
      end else begin
        exp_res[l*DW +: DW] = ok ? src[s*DW +: DW] : '0;
        exp_we[l] = re[l / 16] & be[(l / 4) % 4] & (ok | flag);
      end
    end
    @(posedge clk); @(negedge clk);
    bad_d = 0; bad_w = 0;
    for (int l = 0; l < NL; l++) begin
      if (!bad_d && res[l*DW +: DW] !== exp_res[l*DW +: DW]) begin
        bad_d = 1;
        $display("FAIL %s ctrl=%03h lane %0d data actual=%08h expected=%08h",
                 tag, c, l, res[l*DW +: DW], exp_res[l*DW +: DW]);
      end
    end
    checks++; if (bad_d) errors++;
    if (we !== exp_we) begin
      bad_w = 1;
      $display("FAIL %s ctrl=%03h we actual=%016h expected=%016h", tag, c, we, exp_we);
    end
    checks++; if (bad_w) errors++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    load_src(0);
    ctrl = 9'h140;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    checks++;
    if (res !== '0 || we !== '0) begin
      errors++;
      $display("FAIL R10 reset actual we=%016h expected=0", we);
    end
    rst = 1'b0;

    // Full sweep of every control value, both flag settings.
    for (int c = 0; c < 512; c++) begin
      load_src(c % 7);
      run_case(c, 1'b0, 4'hF, 4'hF, req_of(c));
      run_case(c, 1'b1, 4'hF, 4'hF, req_of(c));
    end

    // R7 / R8: mask pairs on patterns with edge lanes and broadcasts.
    for (int k = 0; k < 256; k++) begin
      run_case(9'h10D, k[0], 4'(k >> 4), 4'(k), "R8");
      run_case(9'h11B, k[1], 4'(k), 4'(k >> 4), "R7");
      run_case(9'h130, k[0], 4'(k >> 4), 4'(k), "R7");
      run_case(9'h142, k[2], 4'(k), 4'(k >> 4), "R8");
      run_case(9'h1E5, k[0], 4'(k), 4'(k >> 4), "R9");
    end

    // R10: reset mid-run clears outputs on the next edge.
    ctrl = 9'h134; bz = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checks++;
    if (res !== '0 || we !== '0) begin
      errors++;
      $display("FAIL R10 mid reset actual we=%016h expected=0", we);
    end
    rst = 1'b0;
    run_case(9'h134, 1'b0, 4'hF, 4'hF, "R10");
    finish_run();
  end
endmodule